// File: doc/BRIEF.md
# Per-Pin Port Mode Controller

This block sets the output drivers of one general-purpose I/O port. Each pin has two configuration bits, one in each of two configuration registers, and they select one of four output types. The block combines the selected type with the pin's output latch bit. From that it produces three enables per pin: a pull-down, a strong pull-up and a weak pull-up. Some pins are fixed in hardware. One pin cannot be anything but an input. Two others accept only the input and open-drain types. A write that asks for a type a pin does not allow is stored as input-only.

On the input side, every pin sample passes through a two-flop synchroniser and then a filter. The filter updates its value only after two equal samples in a row. A separate mask register can switch off the digital input of chosen pins, and those pins then read back as 0. A simple write bus and a combinational read bus give access to the registers and to the filtered pin values.

Top module: `port_mode_ctrl`

## Requirements
- R1: After reset every pin is input-only (type register A reads 0, type register B reads all ones). The output latch reads all ones, the input-disable mask reads 0, and all drive enables are low.
- R2: A pin's type is the two-bit code {B bit, A bit}: 00 quasi-bidirectional, 01 push-pull, 10 input-only, 11 open-drain. Register addresses: 0 output latch, 1 type A, 2 type B, 3 input-disable mask, 4 filtered pin values (read only).
- R3: The pull-down of a pin is on exactly when its latch bit is 0 and its type is not input-only. No pin ever has its pull-down and a pull-up on at the same time.
- R4: In push-pull type the strong pull-up is on for as long as the latch bit is 1.
- R5: In quasi-bidirectional type the weak pull-up is on while the latch bit is 1. The strong pull-up is on for exactly one clock after the latch bit changes from 0 to 1, and a write of 1 over a 1 gives no such pulse.
- R6: In open-drain and input-only types both pull-ups stay off, and in input-only type the pull-down also stays off.
- R7: Pin 5 is always input-only. Writes to its type bits leave its code at 10.
- R8: Pins 2 and 3 allow only input-only and open-drain. A write that would leave either pin at code 00 or 01 stores 10 instead. Each write to A or B checks the combined new code.
- R9: A pin level that changes before a rising edge appears at read address 4 after the fourth rising edge, counting that edge as the first. A pulse that lasts a single clock is never seen.
- R10: A pin whose bit is set in the input-disable mask reads 0 at address 4.
- R11: Writes to address 4 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | NPINS | Write data, one bit per pin |
| rd_addr | input | 3 | Read address |
| rd_data | output | NPINS | Combinational read data |
| pin_in | input | NPINS | Raw pin input samples |
| pd_en | output | NPINS | Pull-down enable per pin |
| spu_en | output | NPINS | Strong pull-up enable per pin |
| wpu_en | output | NPINS | Weak pull-up enable per pin |

## Verification
The bench builds the block with its default values: eight pins, pin 5 fixed as an input, and pins 2 and 3 limited to input-only and open-drain. With eight pins, a sweep that sets every pin to the same type can cover every type under several latch patterns. A further 64 writes with mixed types and mixed write orders then drive the restricted pins through their coercion rules, checked against a model of the registers kept in the bench. The input filter is checked at the exact edge where a level change appears, with a one-clock glitch, with a two-clock pulse, and with the disable mask applied.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int ADDR_W = 3;

  // Register map; the filtered pin view is read only.
  localparam logic [ADDR_W-1:0] ADR_LATCH = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CFGA  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CFGB  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_INDIS = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_PINS  = 3'd4;

  // Code is {type B bit, type A bit}.
  typedef enum logic [1:0] {
    PM_QUASI = 2'b00,
    PM_PUSH  = 2'b01,
    PM_INPUT = 2'b10,
    PM_OPEN  = 2'b11
  } pin_mode_e;

  typedef struct packed {
    logic pd;
    logic spu;
    logic wpu;
  } drive_t;

  // Hardwired pin limits: fixed inputs take only PM_INPUT, restricted
  // pins drop anything with a driven high side back to PM_INPUT.
  function automatic pin_mode_e legal_mode(pin_mode_e req, logic fixed_in,
                                           logic od_only);
    if (fixed_in) return PM_INPUT;
    if (od_only && (req == PM_QUASI || req == PM_PUSH)) return PM_INPUT;
    return req;
  endfunction

  // Drive enables for one pin from its type, latch bit and 0->1 event.
  function automatic drive_t pin_drive(pin_mode_e m, logic lat, logic rise);
    drive_t d;
    d.pd  = ~lat & (m != PM_INPUT);
    d.spu = lat & ((m == PM_PUSH) | ((m == PM_QUASI) & rise));
    d.wpu = lat & (m == PM_QUASI);
    return d;
  endfunction

endpackage

// File: rtl/pmc_cfg_regs.sv
module pmc_cfg_regs
  import pmc_pkg::*;
#(
  parameter int                NPINS       = 8,
  parameter logic [NPINS-1:0]  FIXED_MASK  = 'h20,
  parameter logic [NPINS-1:0]  ODONLY_MASK = 'h0C
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [NPINS-1:0]    wr_data,
  output logic [NPINS-1:0]    latch_q,
  output logic [NPINS-1:0]    cfga_q,
  output logic [NPINS-1:0]    cfgb_q,
  output logic [NPINS-1:0]    indis_q
);

  logic wr_latch, wr_cfga, wr_cfgb, wr_indis;
  logic [NPINS-1:0] nxt_a, nxt_b;

  assign wr_latch = wr_en && (wr_addr == ADR_LATCH);
  assign wr_cfga  = wr_en && (wr_addr == ADR_CFGA);
  assign wr_cfgb  = wr_en && (wr_addr == ADR_CFGB);
  assign wr_indis = wr_en && (wr_addr == ADR_INDIS);

  // Each write is merged with the other register's bit and then limited
  // per pin, so both halves of the code may move on a single write.
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    pin_mode_e  req;
    logic [1:0] ok_bits;
    assign req = pin_mode_e'({wr_cfgb ? wr_data[i] : cfgb_q[i],
                              wr_cfga ? wr_data[i] : cfga_q[i]});
    assign ok_bits  = legal_mode(req, FIXED_MASK[i], ODONLY_MASK[i]);
    assign nxt_a[i] = ok_bits[0];
    assign nxt_b[i] = ok_bits[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
      cfga_q  <= '0;
      cfgb_q  <= '1;
      indis_q <= '0;
    end else begin
      if (wr_latch) latch_q <= wr_data;
      if (wr_cfga || wr_cfgb) begin
        cfga_q <= nxt_a;
        cfgb_q <= nxt_b;
      end
      if (wr_indis) indis_q <= wr_data;
    end
  end

  assert_fixed_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfgb_q & FIXED_MASK) == FIXED_MASK) && ((cfga_q & FIXED_MASK) == '0));

  assert_odonly_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgb_q & ODONLY_MASK) == ODONLY_MASK);

endmodule

// File: rtl/pmc_drive.sv
module pmc_drive
  import pmc_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] latch_q,
  input  logic [NPINS-1:0] cfga_q,
  input  logic [NPINS-1:0] cfgb_q,
  output logic [NPINS-1:0] pd_en,
  output logic [NPINS-1:0] spu_en,
  output logic [NPINS-1:0] wpu_en,
  output logic [NPINS-1:0] rise_evt
);

  logic [NPINS-1:0] latch_prev;
  logic [NPINS-1:0] quasi_pins;
  logic [NPINS-1:0] quasi_kick;

  // Tracks the latch one clock behind; resets to the latch reset value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_prev <= '1;
    else        latch_prev <= latch_q;
  end

  assign rise_evt   = latch_q & ~latch_prev;
  assign quasi_pins = ~cfga_q & ~cfgb_q;
  assign quasi_kick = spu_en & quasi_pins;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    drive_t d;
    assign d = pin_drive(pin_mode_e'({cfgb_q[i], cfga_q[i]}), latch_q[i],
                         rise_evt[i]);
    assign pd_en[i]  = d.pd;
    assign spu_en[i] = d.spu;
    assign wpu_en[i] = d.wpu;
  end

  assert_drive_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_en & (spu_en | wpu_en)) == '0);

  assert_pushpull_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (spu_en & cfga_q & ~cfgb_q) == (latch_q & cfga_q & ~cfgb_q));

  assert_quasi_kick_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (quasi_kick & $past(quasi_kick)) == '0);

endmodule

// File: rtl/pmc_in_filter.sv
module pmc_in_filter #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] filt_q,
  output logic [NPINS-1:0] agree
);

  logic [NPINS-1:0] sync1, sync2, hist;

  assign agree = ~(sync2 ^ hist);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= '0;
      sync2  <= '0;
      hist   <= '0;
      filt_q <= '0;
    end else begin
      sync1  <= pin_in;
      sync2  <= sync1;
      hist   <= sync2;
      filt_q <= (filt_q & ~agree) | (sync2 & agree);
    end
  end

  assert_filter_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((filt_q ^ $past(filt_q)) & ~$past(agree)) == '0);

endmodule

// File: rtl/port_mode_ctrl.sv
module port_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int               NPINS       = 8,
  parameter logic [NPINS-1:0] FIXED_MASK  = 'h20,
  parameter logic [NPINS-1:0] ODONLY_MASK = 'h0C
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [NPINS-1:0]   wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [NPINS-1:0]   rd_data,
  input  logic [NPINS-1:0]   pin_in,
  output logic [NPINS-1:0]   pd_en,
  output logic [NPINS-1:0]   spu_en,
  output logic [NPINS-1:0]   wpu_en
);

  logic [NPINS-1:0] latch_q, cfga_q, cfgb_q, indis_q;
  logic [NPINS-1:0] rise_evt, filt_q, agree, pin_val;

  pmc_cfg_regs #(
    .NPINS(NPINS), .FIXED_MASK(FIXED_MASK), .ODONLY_MASK(ODONLY_MASK)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .latch_q(latch_q), .cfga_q(cfga_q),
    .cfgb_q(cfgb_q), .indis_q(indis_q)
  );

  pmc_drive #(.NPINS(NPINS)) u_drive (
    .clk(clk), .rst_n(rst_n), .latch_q(latch_q), .cfga_q(cfga_q),
    .cfgb_q(cfgb_q), .pd_en(pd_en), .spu_en(spu_en), .wpu_en(wpu_en),
    .rise_evt(rise_evt)
  );

  pmc_in_filter #(.NPINS(NPINS)) u_filt (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .filt_q(filt_q),
    .agree(agree)
  );

  assign pin_val = filt_q & ~indis_q;

  always_comb begin
    case (rd_addr)
      ADR_LATCH: rd_data = latch_q;
      ADR_CFGA:  rd_data = cfga_q;
      ADR_CFGB:  rd_data = cfgb_q;
      ADR_INDIS: rd_data = indis_q;
      ADR_PINS:  rd_data = pin_val;
      default:   rd_data = '0;
    endcase
  end

  assert_quiet_types_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (((spu_en | wpu_en) & cfgb_q) == '0) && ((pd_en & cfgb_q & ~cfga_q) == '0));

  assert_indis_masks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == ADR_PINS) |-> ((rd_data & indis_q) == '0));

  assert_status_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADR_PINS) |=>
      ($stable(latch_q) && $stable(cfga_q) && $stable(cfgb_q) && $stable(indis_q)));

endmodule

// File: tb/port_mode_ctrl_test.sv
`timescale 1ns/1ps
module port_mode_ctrl_test;

  localparam logic [7:0] FIX = 8'h20;
  localparam logic [7:0] OD  = 8'h0C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [7:0] pin_in = '0;
  logic [7:0] pd_en, spu_en, wpu_en;

  int total = 0;
  int bad = 0;

  logic [7:0] ma, mb, mlat, mdis;

  always #2 clk = ~clk;

  port_mode_ctrl #(.NPINS(8), .FIXED_MASK(FIX), .ODONLY_MASK(OD)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .pin_in(pin_in), .pd_en(pd_en), .spu_en(spu_en), .wpu_en(wpu_en)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] allowed(input int i, input logic [1:0] m);
    if (FIX[i]) return 2'b10;
    if (OD[i] && !m[1]) return 2'b10;
    return m;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    logic [1:0] c;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      3'd0: mlat = d;
      3'd1: for (int i = 0; i < 8; i++) begin
              c = allowed(i, {mb[i], d[i]}); mb[i] = c[1]; ma[i] = c[0];
            end
      3'd2: for (int i = 0; i < 8; i++) begin
              c = allowed(i, {d[i], ma[i]}); mb[i] = c[1]; ma[i] = c[0];
            end
      3'd3: mdis = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  // Settled drive check against the bench register model.
  task automatic check_all();
    logic [7:0] epd, espu, ewpu, va, vb;
    logic [1:0] m;
    for (int i = 0; i < 8; i++) begin
      m = {mb[i], ma[i]};
      epd[i]  = !mlat[i] && (m != 2'b10);
      espu[i] = mlat[i] && (m == 2'b01);
      ewpu[i] = mlat[i] && (m == 2'b00);
    end
    chk("R3 R2 pull-down", pd_en, epd);
    chk("R4 R2 strong pull-up", spu_en, espu);
    chk("R5 R2 weak pull-up", wpu_en, ewpu);
    chk("R6 no pull-up in open-drain/input", (spu_en | wpu_en) & mb, 8'h00);
    rd(3'd1, va);
    rd(3'd2, vb);
    chk("R8 type A readback", va, ma);
    chk("R8 type B readback", vb, mb);
    chk("R7 fixed pin code", {6'b0, vb[5], va[5]}, 8'h02);
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] pat;
    ma = 8'h00; mb = 8'hFF; mlat = 8'hFF; mdis = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); chk("R1 latch reset", v, 8'hFF);
    rd(3'd1, v); chk("R1 type A reset", v, 8'h00);
    rd(3'd2, v); chk("R1 type B reset", v, 8'hFF);
    rd(3'd3, v); chk("R1 disable mask reset", v, 8'h00);
    rd(3'd4, v); chk("R1 pin view reset", v, 8'h00);
    chk("R1 drives off", pd_en | spu_en | wpu_en, 8'h00);

    // Uniform type sweep over several latch patterns
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 3; p++) begin
        pat = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : 8'h5A;
        wr(3'd0, pat);
        wr(3'd1, {8{m[0]}});
        wr(3'd2, {8{m[1]}});
        @(negedge clk);
        check_all();
      end
    end

    // Mixed per-pin types with varying write order effects
    for (int k = 0; k < 64; k++) begin
      wr(3'd0, 8'(k * 53));
      if (k[0]) begin
        wr(3'd2, 8'(k * 113 + 7));
        wr(3'd1, 8'(k * 29));
      end else begin
        wr(3'd1, 8'(k * 29));
        wr(3'd2, 8'(k * 113 + 7));
      end
      @(negedge clk);
      check_all();
    end

    // R5 quasi pulse: quasi-capable pins are all but 2, 3 and 5
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h00);
    @(negedge clk);
    wr(3'd0, 8'hFF);
    chk("R5 one-clock strong pull-up", spu_en, 8'hD3);
    @(negedge clk);
    chk("R5 pulse ended", spu_en, 8'h00);
    chk("R5 weak pull-up held", wpu_en, 8'hD3);
    wr(3'd0, 8'hFF);
    chk("R5 no pulse on 1 over 1", spu_en, 8'h00);

    // R9 filter latency
    @(negedge clk);
    pin_in = 8'hFF;
    repeat (3) @(negedge clk);
    rd(3'd4, v); chk("R9 before fourth edge", v, 8'h00);
    @(negedge clk);
    rd(3'd4, v); chk("R9 after fourth edge", v, 8'hFF);

    // R9 one-clock glitch is rejected
    pin_in = 8'h00;
    @(negedge clk);
    pin_in = 8'hFF;
    for (int t = 0; t < 5; t++) begin
      @(negedge clk);
      rd(3'd4, v); chk("R9 glitch rejected", v, 8'hFF);
    end

    // R9 two-clock pulse is accepted
    pin_in = 8'h00;
    @(negedge clk);
    @(negedge clk);
    pin_in = 8'hFF;
    @(negedge clk);
    @(negedge clk);
    rd(3'd4, v); chk("R9 two-clock pulse seen", v, 8'h00);
    repeat (3) @(negedge clk);
    rd(3'd4, v); chk("R9 level restored", v, 8'hFF);

    // R10 digital input disable
    wr(3'd3, 8'h0F);
    rd(3'd3, v); chk("R10 mask readback", v, 8'h0F);
    rd(3'd4, v); chk("R10 disabled pins read 0", v, 8'hF0);

    // R11 write to the pin view changes nothing
    wr(3'd4, 8'h00);
    rd(3'd0, v); chk("R11 latch unchanged", v, mlat);
    rd(3'd1, v); chk("R11 type A unchanged", v, ma);
    rd(3'd2, v); chk("R11 type B unchanged", v, mb);
    rd(3'd3, v); chk("R11 mask unchanged", v, 8'h0F);
    rd(3'd4, v); chk("R11 pin view unchanged", v, 8'hF0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule